// File: doc/BRIEF.md
# DRAM Activity Throttling Controller

This block limits how much weighted command traffic each memory slot may receive in a repeating monitoring window. It sits between a DRAM command scheduler and the command issue stage. It observes one activate event and one read/write event per cycle, each tagged with the slot it targets, and adds a weight to that slot's counter. Once any slot's counter reaches the programmed limit, a single block signal is raised toward the scheduler. That signal holds back requests to all slots until the current window closes.

Throttling does not run all the time. Software programs a configuration word and sets a start bit. An external trigger, which reports that a global sampling threshold was crossed, then opens a throttling session. The session lasts a programmed number of global sampling windows, counted on a sampling tick input. While the session runs, monitoring windows repeat back to back. At each window boundary the per-slot counts clear and the block signal is re-evaluated.

The configuration word and the start bit pass through one register stage before they take effect. Both outputs are registered.

Top module: `dram_throttle`

## Requirements
- R1: The mechanism runs only when the mode field cfg_i[1:0] equals 10 and start_i is high. With the mode field set to 00, 01 or 11, a trigger never makes active_o rise, and an active session ends within two cycles of the mode leaving 10.
- R2: While the mechanism is enabled and no session is active, a trigger sampled at a clock edge sets active_o high after that same edge. A trigger during an active session has no effect.
- R3: An activate adds a weight to the counter of the slot given by act_slot_i. The weight is set by the code in cfg_i[3:2]: 00 adds 2, 01 adds 3, 10 adds 4 and 11 adds 5.
- R4: A read or write adds 2 to the counter of the slot given by rw_slot_i.
- R5: When an activate and a read/write fall in the same cycle, both are counted in that cycle. With different slots, each slot receives its own increment. With the same slot, that slot receives the sum of the two increments.
- R6: Each slot has its own counter. block_o goes high after the edge at which any one slot's count reaches the limit in cfg_i[28:17]. Counts on different slots are never summed.
- R7: The window length is cfg_i[16:10] times 16 cycles, and the first window starts at the edge that opens the session. At each window boundary all counts clear and block_o drops. An event sampled on the boundary edge is counted in the new window.
- R8: The session ends at the edge that samples the D-th pulse of gsw_tick_i, where D is the duration field cfg_i[9:4]. active_o then falls.
- R9: When start_i is cleared, active_o and block_o are both low within two cycles. A later session starts with all counts at zero.
- R10: With a window field of zero or a duration field of zero, no session starts, and active_o and block_o stay low.
- R11: A slot counter saturates at the limit and never wraps. Continued traffic keeps block_o high until the window ends.
- R12: While rst is high and on the cycle after rst is released, active_o and block_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 29 | Configuration word: limit[28:17], window[16:10], duration[9:4], activate weight code[3:2], mode[1:0] |
| start_i | input | 1 | Software start/stop control |
| trig_i | input | 1 | Global sampling threshold crossed |
| gsw_tick_i | input | 1 | One pulse per global sampling window |
| act_vld_i | input | 1 | An activate is issued this cycle |
| act_slot_i | input | 2 | Slot targeted by the activate |
| rw_vld_i | input | 1 | A read or write is issued this cycle |
| rw_slot_i | input | 2 | Slot targeted by the read or write |
| block_o | output | 1 | Hold back requests to all slots |
| active_o | output | 1 | A throttling session is in effect |

## Verification
Two accumulation paths can fall in the same cycle: an activate and a read/write, each aimed at a different slot. The bench provokes this with a single cycle that sends an activate to slot 1 and a read to slot 2 under a limit of 6. It then adds reads to slot 2 until only a correct count of the first, concurrent read makes block_o rise, and it checks block_o before and after that step. A second case sends both events to one slot every cycle until the count runs past the limit. This exercises the same-slot sum and saturation together.

// File: rtl/dram_throttle_pkg.sv
package dram_throttle_pkg;

  localparam int LIM_W   = 12;
  localparam int WIN_W   = 7;
  localparam int DUR_W   = 6;
  localparam int WC_W    = 2;
  localparam int MODE_W  = 2;
  localparam int GRAN_SH = 4;
  localparam int ACTW_W  = 3;
  localparam int RW_WT   = 2;

  localparam logic [MODE_W-1:0] MODE_RUN = 2'b10;
  localparam logic [WC_W-1:0]   WC_RESET = 2'b10;

  typedef struct packed {
    logic [LIM_W-1:0]  limit;
    logic [WIN_W-1:0]  win;
    logic [DUR_W-1:0]  dur;
    logic [WC_W-1:0]   wcode;
    logic [MODE_W-1:0] mode;
  } dt_cfg_t;

  localparam int CFG_W = $bits(dt_cfg_t);

  function automatic logic [ACTW_W-1:0] act_weight(input logic [WC_W-1:0] code);
    return ACTW_W'(code) + ACTW_W'(2);
  endfunction

endpackage

// File: rtl/dt_cfg_reg.sv
module dt_cfg_reg
  import dram_throttle_pkg::*;
#(
  parameter int LEN_W = WIN_W + GRAN_SH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic                start_i,
  output logic                enable,
  output logic [LEN_W-1:0]    win_len,
  output logic [DUR_W-1:0]    dur,
  output logic [LIM_W-1:0]    limit,
  output logic [ACTW_W-1:0]   act_w
);

  localparam dt_cfg_t RST_CFG = '{limit: '0, win: '0, dur: '0,
                                  wcode: WC_RESET, mode: '0};

  dt_cfg_t cfg_q;
  logic    start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= RST_CFG;
      start_q <= 1'b0;
    end else begin
      cfg_q   <= dt_cfg_t'(cfg_i);
      start_q <= start_i;
    end
  end

  always_comb begin
    win_len = {cfg_q.win, {GRAN_SH{1'b0}}};
    dur     = cfg_q.dur;
    limit   = cfg_q.limit;
    act_w   = act_weight(cfg_q.wcode);
    enable  = (cfg_q.mode == MODE_RUN) && start_q &&
              (cfg_q.win != '0) && (cfg_q.dur != '0);
  end

endmodule

// File: rtl/dt_session.sv
module dt_session
  import dram_throttle_pkg::*;
#(
  parameter int LEN_W = WIN_W + GRAN_SH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             trig_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] win_len,
  input  logic [DUR_W-1:0] dur,
  output logic             active_q,
  output logic             active_n,
  output logic             restart
);

  logic [DUR_W-1:0] rem_q, rem_n;
  logic [LEN_W-1:0] wcnt_q, wcnt_n;

  always_comb begin
    active_n = active_q;
    rem_n    = rem_q;
    wcnt_n   = wcnt_q;
    restart  = 1'b0;
    if (!enable) begin
      active_n = 1'b0;
      rem_n    = '0;
      wcnt_n   = '0;
    end else if (!active_q) begin
      if (trig_i) begin
        active_n = 1'b1;
        rem_n    = dur;
        wcnt_n   = '0;
        restart  = 1'b1;
      end
    end else if (tick_i && (rem_q == DUR_W'(1))) begin
      active_n = 1'b0;
      rem_n    = '0;
      wcnt_n   = '0;
    end else begin
      if (tick_i) rem_n = rem_q - DUR_W'(1);
      if (wcnt_q == win_len - LEN_W'(1)) begin
        wcnt_n  = '0;
        restart = 1'b1;
      end else begin
        wcnt_n  = wcnt_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rem_q    <= '0;
      wcnt_q   <= '0;
    end else begin
      active_q <= active_n;
      rem_q    <= rem_n;
      wcnt_q   <= wcnt_n;
    end
  end

endmodule

// File: rtl/dt_slot_cnt.sv
module dt_slot_cnt
  import dram_throttle_pkg::*;
#(
  parameter int SLOT_W = 2,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_vld,
  input  logic [SLOT_W-1:0] act_slot,
  input  logic              rw_vld,
  input  logic [SLOT_W-1:0] rw_slot,
  input  logic [ACTW_W-1:0] act_w,
  input  logic [LIM_W-1:0]  limit,
  input  logic              active_n,
  input  logic              restart,
  output logic              hit_n
);

  localparam int INC_W = ACTW_W + 1;
  localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(IDX);

  logic [LIM_W-1:0] cnt_q, cnt_n, base;
  logic [INC_W-1:0] inc;
  logic [LIM_W:0]   sum;

  always_comb begin
    inc = '0;
    if (act_vld && (act_slot == MY_SLOT)) inc = inc + INC_W'(act_w);
    if (rw_vld && (rw_slot == MY_SLOT))   inc = inc + INC_W'(RW_WT);
    base = restart ? '0 : cnt_q;
    sum  = {1'b0, base} + (LIM_W+1)'(inc);
    if (!active_n)                 cnt_n = '0;
    else if (sum >= {1'b0, limit}) cnt_n = limit;
    else                           cnt_n = sum[LIM_W-1:0];
    hit_n = active_n && (cnt_n >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

endmodule

// File: rtl/dram_throttle.sv
module dram_throttle
  import dram_throttle_pkg::*;
#(
  parameter  int N_SLOTS = 4,
  localparam int SLOT_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              start_i,
  input  logic              trig_i,
  input  logic              gsw_tick_i,
  input  logic              act_vld_i,
  input  logic [SLOT_W-1:0] act_slot_i,
  input  logic              rw_vld_i,
  input  logic [SLOT_W-1:0] rw_slot_i,
  output logic              block_o,
  output logic              active_o
);

  localparam int LEN_W = WIN_W + GRAN_SH;

  logic              enable_w;
  logic [LEN_W-1:0]  win_len_w;
  logic [DUR_W-1:0]  dur_w;
  logic [LIM_W-1:0]  limit_w;
  logic [ACTW_W-1:0] act_w_w;
  logic              active_n_w;
  logic              restart_w;
  logic [N_SLOTS-1:0] hit_w;
  logic              block_q;

  dt_cfg_reg #(.LEN_W(LEN_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .cfg_i   (cfg_i),
    .start_i (start_i),
    .enable  (enable_w),
    .win_len (win_len_w),
    .dur     (dur_w),
    .limit   (limit_w),
    .act_w   (act_w_w)
  );

  dt_session #(.LEN_W(LEN_W)) u_sess (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable_w),
    .trig_i   (trig_i),
    .tick_i   (gsw_tick_i),
    .win_len  (win_len_w),
    .dur      (dur_w),
    .active_q (active_o),
    .active_n (active_n_w),
    .restart  (restart_w)
  );

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    dt_slot_cnt #(.SLOT_W(SLOT_W), .IDX(s)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .act_vld  (act_vld_i),
      .act_slot (act_slot_i),
      .rw_vld   (rw_vld_i),
      .rw_slot  (rw_slot_i),
      .act_w    (act_w_w),
      .limit    (limit_w),
      .active_n (active_n_w),
      .restart  (restart_w),
      .hit_n    (hit_w[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) block_q <= 1'b0;
    else     block_q <= |hit_w;
  end

  assign block_o = block_q;

endmodule

// File: rtl/dram_throttle_chk.sv
module dram_throttle_chk
  import dram_throttle_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [CFG_W-1:0] cfg_i,
  input logic             start_i,
  input logic             trig_i,
  input logic             active_o,
  input logic             block_o,
  input logic             restart_w
);

  dt_cfg_t c;
  assign c = dt_cfg_t'(cfg_i);

  // R1: a mode other than run drains the session within two cycles
  assert_reserved_off_R1: assert property (@(posedge clk) disable iff (rst)
    (c.mode != MODE_RUN) |-> ##2 !active_o);

  // R2: a session only opens in response to a trigger
  assert_trigger_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> $past(trig_i));

  // R9: clearing start drops both outputs
  assert_stop_R9: assert property (@(posedge clk) disable iff (rst)
    !start_i |-> ##2 (!active_o && !block_o));

  // R10: a zero window never lets a session run
  assert_zero_win_R10: assert property (@(posedge clk) disable iff (rst)
    (c.win == '0) |-> ##2 !active_o);

  // R7: block only falls at a window restart or at the end of the session
  assert_block_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(block_o) |-> ($past(restart_w) || !active_o));

endmodule

bind dram_throttle dram_throttle_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_i     (cfg_i),
  .start_i   (start_i),
  .trig_i    (trig_i),
  .active_o  (active_o),
  .block_o   (block_o),
  .restart_w (restart_w)
);

// File: tb/sim_dram_throttle.sv
`timescale 1ns/1ps
module sim_dram_throttle;

  logic        clk = 1'b0;
  logic        rst;
  logic [28:0] cfg_i;
  logic        start_i, trig_i, gsw_tick_i;
  logic        act_vld_i, rw_vld_i;
  logic [1:0]  act_slot_i, rw_slot_i;
  logic        block_o, active_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dram_throttle u0 (
    .clk(clk), .rst(rst), .cfg_i(cfg_i), .start_i(start_i), .trig_i(trig_i),
    .gsw_tick_i(gsw_tick_i), .act_vld_i(act_vld_i), .act_slot_i(act_slot_i),
    .rw_vld_i(rw_vld_i), .rw_slot_i(rw_slot_i), .block_o(block_o),
    .active_o(active_o)
  );

  // columns: weight code, activates, read/writes, limit, expected block
  localparam int NV = 10;
  localparam int VEC [NV][5] = '{
    '{0, 3, 0,    6, 1},
    '{0, 2, 0,    6, 0},
    '{1, 2, 0,    6, 1},
    '{1, 1, 1,    6, 0},
    '{2, 1, 1,    6, 1},
    '{3, 1, 0,    5, 1},
    '{3, 1, 0,    6, 0},
    '{2, 0, 5,   10, 1},
    '{2, 0, 4,   10, 0},
    '{3, 5, 0, 4095, 0}
  };

  function automatic logic [28:0] mk(int lim, int win, int dur, int code, int mode);
    return {12'(lim), 7'(win), 6'(dur), 2'(code), 2'(mode)};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go(int lim, int win, int dur, int code, int mode);
    cfg_i   = mk(lim, win, dur, code, mode);
    start_i = 1'b1;
    step();
    step();
    trig_i = 1'b1;
    step();
    trig_i = 1'b0;
  endtask

  task automatic halt();
    start_i = 1'b0;
    step();
    step();
    step();
  endtask

  task automatic ev(bit av, int as, bit rv, int rs);
    act_vld_i  = av;
    act_slot_i = 2'(as);
    rw_vld_i   = rv;
    rw_slot_i  = 2'(rs);
    step();
    act_vld_i  = 1'b0;
    rw_vld_i   = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    rst = 1'b1; cfg_i = '0; start_i = 0; trig_i = 0; gsw_tick_i = 0;
    act_vld_i = 0; rw_vld_i = 0; act_slot_i = 0; rw_slot_i = 0;
    step(); step();
    chk("R12 active in reset", int'(active_o), 0);
    chk("R12 block in reset", int'(block_o), 0);
    rst = 1'b0;
    step();
    chk("R12 active after reset", int'(active_o), 0);

    // table walk: R3 activate weights, R4 read/write weight, R6 limit
    for (int v = 0; v < NV; v++) begin
      go(VEC[v][3], 4, 63, VEC[v][0], 2);
      chk("R2 session opens", int'(active_o), 1);
      for (int k = 0; k < VEC[v][1]; k++) ev(1, 0, 0, 0);
      for (int k = 0; k < VEC[v][2]; k++) ev(0, 0, 1, 0);
      chk($sformatf("R3 R4 R6 vector %0d", v), int'(block_o), VEC[v][4]);
      halt();
      chk("R9 stopped", int'(active_o), 0);
    end

    // R5: concurrent activate and read to different slots
    go(6, 4, 63, 2, 2);
    ev(1, 1, 1, 2);
    chk("R5 after concurrent", int'(block_o), 0);
    ev(0, 0, 1, 2);
    chk("R5 slot2 at 4", int'(block_o), 0);
    ev(0, 0, 1, 2);
    chk("R5 slot2 reaches 6", int'(block_o), 1);
    halt();

    // R6: slots counted separately
    go(6, 4, 63, 0, 2);
    ev(1, 0, 0, 0); ev(1, 0, 0, 0); ev(1, 3, 0, 0); ev(1, 3, 0, 0);
    chk("R6 no cross-slot sum", int'(block_o), 0);
    ev(1, 3, 0, 0);
    chk("R6 slot3 reaches limit", int'(block_o), 1);
    halt();

    // R7: window boundary, window = 16 cycles
    go(2, 1, 63, 0, 2);
    ev(0, 0, 1, 0);
    chk("R7 block in window", int'(block_o), 1);
    repeat (14) step();
    chk("R7 block until boundary", int'(block_o), 1);
    step();
    chk("R7 block clears at boundary", int'(block_o), 0);
    chk("R7 session continues", int'(active_o), 1);
    ev(0, 0, 1, 0);
    chk("R7 next window counts", int'(block_o), 1);
    halt();

    // R8: duration of two sampling windows
    go(4095, 1, 2, 0, 2);
    trig_i = 1'b1; step(); trig_i = 1'b0;
    gsw_tick_i = 1'b1; step(); gsw_tick_i = 1'b0;
    chk("R8 active after first tick", int'(active_o), 1);
    step();
    gsw_tick_i = 1'b1; step(); gsw_tick_i = 1'b0;
    chk("R8 ends on second tick", int'(active_o), 0);
    halt();

    // R1: modes 00, 01, 11 never start
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      go(4, 4, 63, 0, m);
      chk($sformatf("R1 mode %0d", m), int'(active_o), 0);
      halt();
    end

    // R10: zero window, zero duration
    go(0, 0, 63, 0, 2);
    chk("R10 zero window", int'(active_o), 0);
    chk("R10 zero window block", int'(block_o), 0);
    halt();
    go(0, 4, 0, 0, 2);
    chk("R10 zero duration", int'(active_o), 0);
    chk("R10 zero duration block", int'(block_o), 0);
    halt();

    // R9: stop mid-session, restart from zero counts
    go(4, 4, 63, 0, 2);
    ev(1, 0, 0, 0);
    start_i = 1'b0;
    step(); step();
    chk("R9 active cleared", int'(active_o), 0);
    chk("R9 block cleared", int'(block_o), 0);
    go(4, 4, 63, 0, 2);
    ev(1, 0, 0, 0);
    chk("R9 counts restart at zero", int'(block_o), 0);
    halt();

    // R11: saturation at the top limit, same-slot sum of 7 per cycle
    go(4095, 127, 63, 3, 2);
    act_vld_i = 1; rw_vld_i = 1; act_slot_i = 0; rw_slot_i = 0;
    repeat (600) step();
    act_vld_i = 0; rw_vld_i = 0;
    chk("R11 saturated block holds", int'(block_o), 1);
    chk("R5 same slot summed", int'(active_o), 1);

    // R12: reset during a session
    rst = 1'b1;
    step();
    chk("R12 reset mid-session active", int'(active_o), 0);
    chk("R12 reset mid-session block", int'(block_o), 0);
    rst = 1'b0;
    step();

    summary();
  end

endmodule